// File: doc/BRIEF.md
# Two-Stage I2C SCL Rate Divider

This block derives the bit-rate timing of an I2C controller from the peripheral clock. A fixed prescaler divides the clock by 22. Two programmable stages follow it, one dividing by (divA + 1) and one by (divB + 1). The block produces two single-cycle enable pulses: one at the prescaled rate and one at the SCL rate. The SCL rate therefore equals the clock frequency divided by 22 × (divA + 1) × (divB + 1).

A master-mode bit engine uses the SCL-rate pulse to pace its clock and data phases. In slave mode the same pulse sets how often an external SCL line is sampled, so the divisors must be chosen to make that rate at least as fast as the fastest SCL on the bus.

The divisor fields come directly from a control word. divA is a 2-bit value (0 to 3) and divB is a 6-bit value (0 to 63). A new field value is adopted only when its own stage reaches terminal count, so the stage never emits a shortened period. Clearing the enable input returns every counter to zero.

Top module: `sclRateGen`

## Requirements
- R1: After reset, and for as long as `enable` is low, neither `prescaleTick` nor `sclTick` is asserted.
- R2: Once `enable` is high, `prescaleTick` is a one-cycle pulse on the 22nd enabled cycle and on every 22nd cycle after that.
- R3: `sclTick` is a one-cycle pulse whose first occurrence falls on enabled cycle 22·(divA+1)·(divB+1). It then repeats with exactly that period.
- R4: With divA = 0 and divB = 0, `sclTick` fires every 22 cycles, in the same cycles as `prescaleTick`.
- R5: Dropping `enable` returns all three counters to zero. After `enable` rises again, the first `sclTick` comes a full period later.
- R6: A change of divA while enabled does not shorten or stretch the current divA period. The new value governs from the period that starts after the next divA terminal count.
- R7: A change of divB while enabled completes the current SCL period with the old value. The new value governs from the next period.
- R8: `sclTick` is never asserted in a cycle without `prescaleTick`.
- R9: Divisor values set while `enable` is low govern from the very first enabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the divider; low clears all counters |
| divA | input | 2 | First programmable divisor minus one |
| divB | input | 6 | Second programmable divisor minus one |
| prescaleTick | output | 1 | One-cycle pulse every 22 enabled cycles |
| sclTick | output | 1 | One-cycle pulse at the SCL rate |

## Verification
The bench runs the divider over every divA value crossed with divB values 0 to 7, plus the largest setting. For each combination it measures the cycle of the first SCL pulse, the cycle of the second, and the number of prescale pulses in between. These measurements catch an off-by-one in any stage and a swapped or ignored divisor. A setting that changes divA alone and one that changes divB alone mid-period show whether a new value is adopted at the stage boundary or too early. A disable placed in the middle of a period checks that all counters restart together.

// File: rtl/sclDivPkg.sv
package sclDivPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic run;
  } ctrlStrobes_t;

  // terminal-count pulses from datapath back to control
  typedef struct packed {
    logic preTc;
    logic aTc;
    logic bTc;
  } tickSet_t;

endpackage

// File: rtl/sclDivStage.sv
module sclDivStage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         term,
  output logic [W-1:0] cnt
);

  assign term = step && (cnt == lim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (step)     cnt <= term ? '0 : cnt + W'(1);
  end

  // R5: a clear leaves the stage at zero
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> cnt == '0);

  // R6 / R7: a running stage never counts past its active limit
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    !clear |-> cnt <= lim);

endmodule

// File: rtl/sclDivCtrl.sv
module sclDivCtrl
  import sclDivPkg::*;
#(
  parameter int DIVA_W = 2,
  parameter int DIVB_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIVA_W-1:0] divA,
  input  logic [DIVB_W-1:0] divB,
  input  tickSet_t          ticks,
  output ctrlStrobes_t      ctl,
  output logic [DIVA_W-1:0] limA,
  output logic [DIVB_W-1:0] limB
);

  assign ctl.clearAll = !enable;
  assign ctl.run      = enable;

  // active divisors: follow the field while idle, else only at the stage boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limA <= '0;
      limB <= '0;
    end else begin
      if (!enable || ticks.aTc) limA <= divA;
      if (!enable || ticks.bTc) limB <= divB;
    end
  end

  // R6: mid-period the active divA value is held
  a_r6_hold_a: assert property (@(posedge clk) disable iff (!rstN)
    enable && !ticks.aTc |=> $stable(limA));

  // R7: mid-period the active divB value is held
  a_r7_hold_b: assert property (@(posedge clk) disable iff (!rstN)
    enable && !ticks.bTc |=> $stable(limB));

  // R9: while idle the field is captured for the first enabled period
  a_r9_idle_capture: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> limB == $past(divB));

endmodule

// File: rtl/sclDivPath.sv
module sclDivPath
  import sclDivPkg::*;
#(
  parameter int PRESCALE = 22,
  parameter int DIVA_W   = 2,
  parameter int DIVB_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [DIVA_W-1:0] limA,
  input  logic [DIVB_W-1:0] limB,
  output tickSet_t          ticks
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LIM = PRE_W'(PRESCALE - 1);

  logic preTc;
  logic aTc;
  logic bTc;
  logic [DIVA_W-1:0] cntA;
  logic [DIVB_W-1:0] cntB;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] cntPre;
      sclDivStage #(.W(PRE_W)) uPre (
        .clk(clk), .rstN(rstN), .clear(ctl.clearAll), .step(ctl.run),
        .lim(PRE_LIM), .term(preTc), .cnt(cntPre)
      );
    end else begin : g_nopre
      assign preTc = ctl.run;
    end
  endgenerate

  sclDivStage #(.W(DIVA_W)) uStageA (
    .clk(clk), .rstN(rstN), .clear(ctl.clearAll), .step(preTc),
    .lim(limA), .term(aTc), .cnt(cntA)
  );

  sclDivStage #(.W(DIVB_W)) uStageB (
    .clk(clk), .rstN(rstN), .clear(ctl.clearAll), .step(aTc),
    .lim(limB), .term(bTc), .cnt(cntB)
  );

  assign ticks.preTc = preTc;
  assign ticks.aTc   = aTc;
  assign ticks.bTc   = bTc;

  // R1: an idle divider emits no prescale pulse
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearAll |-> !preTc);

  // R3: after a final-stage terminal count both programmable counters restart
  a_r3_wrap_all: assert property (@(posedge clk) disable iff (!rstN)
    bTc && !ctl.clearAll |=> cntA == '0 && cntB == '0);

endmodule

// File: rtl/sclRateGen.sv
module sclRateGen
  import sclDivPkg::*;
#(
  parameter int PRESCALE = 22,
  parameter int DIVA_W   = 2,
  parameter int DIVB_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIVA_W-1:0] divA,
  input  logic [DIVB_W-1:0] divB,
  output logic              prescaleTick,
  output logic              sclTick
);

  ctrlStrobes_t      ctl;
  tickSet_t          ticks;
  logic [DIVA_W-1:0] limA;
  logic [DIVB_W-1:0] limB;

  sclDivCtrl #(.DIVA_W(DIVA_W), .DIVB_W(DIVB_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .divA(divA), .divB(divB),
    .ticks(ticks), .ctl(ctl), .limA(limA), .limB(limB)
  );

  sclDivPath #(.PRESCALE(PRESCALE), .DIVA_W(DIVA_W), .DIVB_W(DIVB_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .limA(limA), .limB(limB), .ticks(ticks)
  );

  assign prescaleTick = ticks.preTc;
  assign sclTick      = ticks.bTc;

  // R8: an SCL pulse always lands on a prescale pulse
  a_r8_scl_on_pre: assert property (@(posedge clk) disable iff (!rstN)
    sclTick |-> prescaleTick);

  // R2: prescale pulses last one cycle
  a_r2_pre_single: assert property (@(posedge clk) disable iff (!rstN)
    prescaleTick |=> !prescaleTick);

endmodule

// File: tb/sclRateGen_test.sv
`timescale 1ns/1ps
module sclRateGen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] divA = '0;
  logic [5:0] divB = '0;
  logic       prescaleTick;
  logic       sclTick;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  sclRateGen uut (
    .clk(clk), .rstN(rstN), .enable(enable), .divA(divA), .divB(divB),
    .prescaleTick(prescaleTick), .sclTick(sclTick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Samples n cycles; index i is the state after i rising edges from the start.
  // At index chgAt the fields are replaced by newA/newB.
  task automatic runWindow(input int n, input int chgAt, input int newA, input int newB,
                           output int idx[4], output int nScl, output int nPre,
                           output int badCoin);
    nScl = 0; nPre = 0; badCoin = 0;
    for (int k = 0; k < 4; k++) idx[k] = -1;
    for (int i = 0; i < n; i++) begin
      if (i == chgAt) begin
        divA = 2'(newA);
        divB = 6'(newB);
      end
      #1;
      if (prescaleTick) nPre++;
      if (sclTick) begin
        if (nScl < 4) idx[nScl] = i;
        nScl++;
        if (!prescaleTick) badCoin++;
      end
      @(negedge clk);
    end
  endtask

  task automatic startWith(input int a, input int b);
    @(negedge clk);
    enable = 1'b0;
    divA = 2'(a);
    divB = 6'(b);
    @(negedge clk);
    @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin : watchdog
    while (cycles < 190000 && !finished) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int idx[4];
    int nScl, nPre, bad, per;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 reset scl", int'(sclTick), 0);
    check("R1 reset pre", int'(prescaleTick), 0);
    rstN = 1'b1;
    @(negedge clk);
    runWindow(60, -1, 0, 0, idx, nScl, nPre, bad);
    check("R1 idle pre count", nPre, 0);
    check("R1 idle scl count", nScl, 0);

    // R4 and R2: both divisors zero
    startWith(0, 0);
    runWindow(22 * 5, -1, 0, 0, idx, nScl, nPre, bad);
    check("R4 scl count", nScl, 5);
    check("R4 first scl", idx[0], 21);
    check("R4 second scl", idx[1], 43);
    check("R4 coincide", bad, 0);
    check("R2 pre count", nPre, 5);

    // R3 / R2 / R8 / R9 sweep
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 9; b++) begin
        int bb;
        bb = (b == 8) ? 63 : b;
        if (b == 8 && a != 3) continue;
        per = 22 * (a + 1) * (bb + 1);
        startWith(a, bb);
        runWindow(2 * per, -1, 0, 0, idx, nScl, nPre, bad);
        check($sformatf("R3 R9 first a=%0d b=%0d", a, bb), idx[0], per - 1);
        check($sformatf("R3 second a=%0d b=%0d", a, bb), idx[1], 2 * per - 1);
        check($sformatf("R3 count a=%0d b=%0d", a, bb), nScl, 2);
        check($sformatf("R2 pre a=%0d b=%0d", a, bb), nPre, 2 * (a + 1) * (bb + 1));
        check($sformatf("R8 a=%0d b=%0d", a, bb), bad, 0);
      end
    end

    // R6: divA 3 -> 0 at index 30 with divB 0
    startWith(3, 0);
    runWindow(140, 30, 0, 0, idx, nScl, nPre, bad);
    check("R6 old period", idx[0], 87);
    check("R6 new period 1", idx[1], 109);
    check("R6 new period 2", idx[2], 131);

    // R7: divB 5 -> 1 at index 50 with divA 0
    startWith(0, 5);
    runWindow(230, 50, 0, 1, idx, nScl, nPre, bad);
    check("R7 old period", idx[0], 131);
    check("R7 new period 1", idx[1], 175);
    check("R7 new period 2", idx[2], 219);

    // R5: disable mid-period then restart
    startWith(1, 1);
    runWindow(61, -1, 0, 0, idx, nScl, nPre, bad);
    check("R5 no early scl", nScl, 0);
    enable = 1'b0;
    runWindow(3, -1, 0, 0, idx, nScl, nPre, bad);
    check("R5 quiet pre", nPre, 0);
    check("R5 quiet scl", nScl, 0);
    enable = 1'b1;
    runWindow(176, -1, 1, 1, idx, nScl, nPre, bad);
    check("R5 restart first", idx[0], 87);
    check("R5 restart second", idx[1], 175);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule